// File: doc/BRIEF.md
# Periodic Snapshot and Interrupt Controller

This block sets the pace of a fixed-rate control loop shared between on-chip logic and a host processor. A divider built from the system clock produces a low-rate cycle tick, nominally 4 kHz, which is one cycle every 250 µs. On each tick the block freezes a wide bus of changing input values into a bank of holding registers. One clock later it raises an interrupt, so the host only reads data that is already in place.

Once a snapshot is taken, the cycle stays "busy" until the host signals `host_done`. A budget timer measures the time the host takes. If the host has not finished within the allowed window (nominally 200 µs), the interrupt is withdrawn and a sticky overrun flag is raised. A tick that arrives while the previous cycle is still busy does not overwrite the holding registers, because the host may still be reading them. That tick is skipped and also flags an overrun. The logic and the host therefore never work on the same registers at the same time.

Top module: `snap_irq_ctrl`

## Requirements
- R1: While reset is held low, `held_data`, `irq` and `overrun` are all 0.
- R2: A cycle tick occurs every `TICK_COUNT` clocks. The first tick takes effect on the `TICK_COUNT`-th rising edge after reset is released. At an accepted tick, `held_data` takes the value `live_data` had at that edge.
- R3: `irq` rises on the clock edge that follows the snapshot load, unless `host_done` is high in the cycle between the two.
- R4: `host_done` sampled high while a cycle is busy ends that cycle, and `irq` is 0 after that edge. A cycle finished in this way does not set `overrun`.
- R5: A window opens at each accepted tick. If no `host_done` arrives within the `WINDOW_COUNT` clocks that follow, then at the `WINDOW_COUNT`-th edge after the tick `irq` falls to 0 and `overrun` is set. The cycle stays busy until `host_done` arrives.
- R6: A tick that arrives while a cycle is busy and `host_done` is low leaves `held_data` unchanged and sets `overrun`.
- R7: `overrun` stays at 1 until `overrun_clr` is sampled high. When a set condition and `overrun_clr` occur in the same cycle, the set wins.
- R8: When `host_done` and a tick fall in the same cycle of a busy period, the done takes effect first. The tick is accepted, the snapshot is taken, `overrun` is not set, and `irq` rises one edge later.
- R9: `host_done` has no effect when no cycle is busy. `irq` and `overrun` stay unchanged, and the next tick is accepted normally.
- R10: `held_data` changes only on the edge of an accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_data | input | NUM_REGS*DATA_W | Transient values to be captured |
| held_data | output | NUM_REGS*DATA_W | Stable snapshot for the host to read |
| irq | output | 1 | New-data interrupt to the host |
| host_done | input | 1 | Host has finished read, compute and write-back |
| overrun_clr | input | 1 | Clears the sticky overrun flag |
| overrun | output | 1 | Sticky flag for a budget miss or a skipped tick |

## Verification
Two pairs of events can land in the same cycle. The host's done pulse can coincide with a cycle tick, and an overrun-clear request can coincide with a new overrun cause. The bench predicts the tick and window edges from its own behavioural model. It drives `host_done` into exactly the cycle before a tick edge and expects the snapshot to be taken with no overrun. It also drives `overrun_clr` into the cycle of a window expiry and expects the flag to survive. A per-clock comparison against the model judges every other interleaving the sequence produces.

// File: rtl/snapirq_pkg.sv
package snapirq_pkg;

  // True when a free-running count has reached its last value before wrapping.
  function automatic logic at_last(input logic [31:0] value, input logic [31:0] limit);
    return (value == (limit - 32'd1));
  endfunction

  // Sticky flag update: a set request dominates a clear request.
  function automatic logic sticky_next(input logic set_req, input logic clr_req, input logic cur);
    return set_req | (cur & ~clr_req);
  endfunction

  // A tick may load the bank when the loop is idle or is being released this very cycle.
  function automatic logic tick_takes(input logic tick, input logic busy, input logic done);
    return tick & (~busy | done);
  endfunction

endpackage

// File: rtl/cycle_divider.sv
module cycle_divider
  import snapirq_pkg::*;
#(
  parameter int unsigned TICK_COUNT = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_COUNT > 1) ? $clog2(TICK_COUNT) : 1;

  logic [CW-1:0] div_q;

  assign tick = at_last(32'(div_q), 32'(TICK_COUNT));

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + CW'(1);
  end
endmodule

// File: rtl/budget_timer.sv
module budget_timer
  import snapirq_pkg::*;
#(
  parameter int unsigned WINDOW_COUNT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic active,
  output logic expire
);
  localparam int unsigned WW = (WINDOW_COUNT > 1) ? $clog2(WINDOW_COUNT) : 1;

  logic [WW-1:0] elapsed_q;
  logic          active_q;

  assign active = active_q;
  assign expire = active_q & ~stop & at_last(32'(elapsed_q), 32'(WINDOW_COUNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      elapsed_q <= '0;
    end else if (start) begin
      active_q  <= 1'b1;
      elapsed_q <= '0;
    end else if (stop || expire) begin
      active_q  <= 1'b0;
    end else if (active_q) begin
      elapsed_q <= elapsed_q + WW'(1);
    end
  end
endmodule

// File: rtl/hold_bank.sv
module hold_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_REGS*DATA_W-1:0]   din,
  output logic [NUM_REGS*DATA_W-1:0]   dout
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    lane_q <= '0;
      else if (load) lane_q <= din[g*DATA_W +: DATA_W];
    end
    assign dout[g*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/snap_irq_ctrl.sv
module snap_irq_ctrl
  import snapirq_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned NUM_REGS     = 4,
  parameter int unsigned TICK_COUNT   = 12500,
  parameter int unsigned WINDOW_COUNT = 10000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REGS*DATA_W-1:0]  live_data,
  output logic [NUM_REGS*DATA_W-1:0]  held_data,
  output logic                        irq,
  input  logic                        host_done,
  input  logic                        overrun_clr,
  output logic                        overrun
);
  localparam int unsigned BUS_W = NUM_REGS * DATA_W;

  // Named events, visible to the bound checker.
  logic cycle_tick;
  logic done_evt;
  logic accept_evt;
  logic skip_evt;
  logic expire_evt;
  logic win_active;

  logic busy_q;
  logic snap_q;
  logic irq_q;
  logic ovr_q;

  assign done_evt   = host_done & busy_q;
  assign accept_evt = tick_takes(cycle_tick, busy_q, host_done);
  assign skip_evt   = cycle_tick & busy_q & ~host_done;

  cycle_divider #(.TICK_COUNT(TICK_COUNT)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cycle_tick)
  );

  budget_timer #(.WINDOW_COUNT(WINDOW_COUNT)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept_evt),
    .stop   (done_evt),
    .active (win_active),
    .expire (expire_evt)
  );

  hold_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_evt),
    .din   (live_data),
    .dout  (held_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      snap_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      snap_q <= accept_evt;
      ovr_q  <= sticky_next(skip_evt | expire_evt, overrun_clr, ovr_q);

      if (accept_evt)    busy_q <= 1'b1;
      else if (done_evt) busy_q <= 1'b0;

      if (accept_evt)                   irq_q <= 1'b0;
      else if (done_evt || expire_evt)  irq_q <= 1'b0;
      else if (snap_q && win_active)    irq_q <= 1'b1;
    end
  end

  assign irq     = irq_q;
  assign overrun = ovr_q;

  logic unused_w;
  assign unused_w = ^BUS_W;
endmodule

// File: rtl/snap_irq_ctrl_chk.sv
module snap_irq_ctrl_chk #(
  parameter int unsigned BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] held_data,
  input logic             irq,
  input logic             overrun,
  input logic             host_done,
  input logic             overrun_clr,
  input logic             accept_evt,
  input logic             skip_evt,
  input logic             expire_evt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq && !overrun));

  a_r3_irq_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt ##1 !host_done |=> irq);

  a_r4_done_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && irq) |=> !irq);

  a_r5_budget_miss: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (overrun && !irq));

  a_r6_busy_tick_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> (overrun && $stable(held_data)));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  a_r10_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(held_data));
endmodule

bind snap_irq_ctrl snap_irq_ctrl_chk #(.BUS_W(NUM_REGS * DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .held_data   (held_data),
  .irq         (irq),
  .overrun     (overrun),
  .host_done   (host_done),
  .overrun_clr (overrun_clr),
  .accept_evt  (accept_evt),
  .skip_evt    (skip_evt),
  .expire_evt  (expire_evt)
);

// File: tb/snap_irq_ctrl_test.sv
module snap_irq_ctrl_test;
  localparam int DW = 8;
  localparam int NR = 4;
  localparam int TC = 40;
  localparam int WC = 30;
  localparam int BW = DW * NR;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [BW-1:0] live_data;
  logic [BW-1:0] held_data;
  logic          irq;
  logic          host_done;
  logic          overrun_clr;
  logic          overrun;

  always #10 clk = ~clk;

  snap_irq_ctrl #(.DATA_W(DW), .NUM_REGS(NR), .TICK_COUNT(TC), .WINDOW_COUNT(WC)) uut (
    .clk(clk), .rst_n(rst_n), .live_data(live_data), .held_data(held_data),
    .irq(irq), .host_done(host_done), .overrun_clr(overrun_clr), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int            m_phase, m_elapsed;
  bit            m_busy, m_fresh, m_irq, m_open, m_flag;
  logic [BW-1:0] m_held;

  always @(posedge clk) begin : model
    bit tk, dn, take, miss, late;
    if (!rst_n) begin
      m_phase = 0; m_elapsed = 0; m_busy = 0; m_fresh = 0;
      m_irq = 0; m_open = 0; m_flag = 0; m_held = '0;
    end else begin
      tk   = (m_phase == TC - 1);
      dn   = host_done && m_busy;
      take = tk && (!m_busy || dn);
      miss = tk && m_busy && !dn;
      late = m_open && (m_elapsed == WC - 1) && !dn;
      if (take) m_irq = 0;
      else if (dn || late) m_irq = 0;
      else if (m_fresh && m_open) m_irq = 1;
      m_flag  = (miss || late) ? 1'b1 : (overrun_clr ? 1'b0 : m_flag);
      if (take) begin m_open = 1; m_elapsed = 0; end
      else if (dn || late) m_open = 0;
      else if (m_open) m_elapsed++;
      if (take) m_busy = 1; else if (dn) m_busy = 0;
      if (take) m_held = live_data;
      m_fresh = take;
      m_phase = tk ? 0 : m_phase + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(held_data === m_held, "R10 held vs model", held_data, m_held);
      check(irq === m_irq, "R3 irq vs model", BW'(irq), BW'(m_irq));
      check(overrun === m_flag, "R7 overrun vs model", BW'(overrun), BW'(m_flag));
    end
  end

  task automatic step();
    @(negedge clk);
    live_data = $urandom;
  endtask

  task automatic to_tick();
    while (m_phase != TC - 1) step();
  endtask

  task automatic to_expire();
    while (!(m_open && m_elapsed == WC - 1)) step();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin : stim
    logic [BW-1:0] exp_v;
    rst_n = 1'b0; host_done = 1'b0; overrun_clr = 1'b0; live_data = '1;
    repeat (3) step();
    check(held_data == '0, "R1 held", held_data, '0);
    check(!irq, "R1 irq", BW'(irq), '0);
    check(!overrun, "R1 overrun", BW'(overrun), '0);
    rst_n = 1'b1;

    // Normal cycle answered in time.
    to_tick(); exp_v = live_data; step();
    check(held_data == exp_v, "R2 snapshot value", held_data, exp_v);
    check(!irq, "R3 irq low on load edge", BW'(irq), '0);
    step();
    check(irq, "R3 irq one edge after load", BW'(irq), BW'(1));
    repeat (3) step();
    host_done = 1'b1; step(); host_done = 1'b0;
    check(!irq, "R4 irq dropped by done", BW'(irq), '0);
    check(!overrun, "R4 no overrun", BW'(overrun), '0);

    // Done while idle.
    host_done = 1'b1; step(); host_done = 1'b0;
    check(!irq && !overrun, "R9 idle done ignored", {irq, overrun}, '0);
    to_tick(); exp_v = live_data; step();
    check(held_data == exp_v, "R9 next tick still copies", held_data, exp_v);

    // Budget miss, then a tick during the busy period.
    to_expire(); step();
    check(overrun, "R5 overrun on expiry", BW'(overrun), BW'(1));
    check(!irq, "R5 irq withdrawn", BW'(irq), '0);
    overrun_clr = 1'b1; step(); overrun_clr = 1'b0;
    check(!overrun, "R7 clear", BW'(overrun), '0);
    to_tick(); exp_v = held_data; step();
    check(held_data == exp_v, "R6 copy skipped", held_data, exp_v);
    check(overrun, "R6 overrun on busy tick", BW'(overrun), BW'(1));

    // Done in the same cycle as a tick.
    overrun_clr = 1'b1; step(); overrun_clr = 1'b0;
    to_tick(); host_done = 1'b1; exp_v = live_data; step(); host_done = 1'b0;
    check(held_data == exp_v, "R8 tick accepted with done", held_data, exp_v);
    check(!overrun, "R8 no overrun", BW'(overrun), '0);
    step();
    check(irq, "R8 irq follows", BW'(irq), BW'(1));

    // Clear in the same cycle as a new overrun cause.
    to_expire(); overrun_clr = 1'b1; step(); overrun_clr = 1'b0;
    check(overrun, "R7 set beats clear", BW'(overrun), BW'(1));
    repeat (5) step();
    check(overrun, "R7 sticky", BW'(overrun), BW'(1));
    host_done = 1'b1; step(); host_done = 1'b0;
    overrun_clr = 1'b1; step(); overrun_clr = 1'b0;

    // One more answered cycle and a quiet stretch.
    to_tick(); step(); step();
    host_done = 1'b1; step(); host_done = 1'b0;
    exp_v = held_data;
    repeat (10) step();
    check(held_data == exp_v, "R10 bank stable between ticks", held_data, exp_v);
    step();
    finish_run();
  end
endmodule